// File: doc/BRIEF.md
# Banked Processor Access Port for a Time-Slot Switch

This block is the slave side of an asynchronous microprocessor bus on a time-slot switch. The bus master drives an active-low select, an active-high strobe, a read/write line (high means read), a six-bit address and a byte of write data. The block answers on an active-low acknowledge line. The acknowledge is modelled as a plain output that an open-drain pad would turn into a pull-down. Read data comes back on a separate output byte with its own drive enable. The select and strobe lines are brought into the block clock domain through a synchronizer of configurable depth. Address, read/write and write data are taken as stable while the strobe is held.

The block holds one control byte. It has a split flag, a global message flag, a two-bit memory selector and a three-bit stream number. With address bit 5 clear, the access goes to this byte. With address bit 5 set, the low five address bits pick a channel, and the control byte supplies the memory and the stream. Together they form the memory word address and the memory selection that the block drives towards the switch memories. The serial engine owns the memories except in one processor slot per channel time, which it signals with a one-cycle pulse. Every memory access, and every control read, waits for that pulse and is acknowledged just after it. A control write is applied and acknowledged at once.

Top module: `cpu_bank_port`

## Requirements
- R1: After reset the acknowledge is high, the read-data enable is low, the split and global message outputs are 0, and the control byte reads back as 8'h00.
- R2: When address bit 5 is 0, the access targets the control byte, whatever address bits 4..0 hold. Bit 5 of the control byte always reads back as 0, and all other bits read back as written.
- R3: A control write is acknowledged exactly SYNC_STAGES+1 clock cycles after the strobe is asserted, independent of the processor slot.
- R4: Every other access (memory read, memory write, control read) is acknowledged in the clock cycle right after a cycle in which `slot_i` was high. The memory strobes are only active in such a slot cycle.
- R5: When address bit 5 is 1 and split is off, `mem_addr` = {control[2:0], address[4:0]} and `mem_sel` = control[4:3]. The selector codes are 01 for data memory, 10 for the low connection memory and 11 for the high connection memory.
- R6: With control bit 7 (split) set, memory reads go to the data memory and memory writes go to the low connection memory, whatever the selector holds.
- R7: The high connection memory keeps 3 bits. Writes present data bits 7..3 as 0, and reads return bits 7..3 as 0.
- R8: A write to the data memory, or a write with selector 00, is acknowledged but raises no `mem_we`. A read with selector 00 returns 8'h00.
- R9: The acknowledge stays low while select and strobe are held, and returns high SYNC_STAGES+1 cycles after the strobe is released. During a read acknowledge `bus_dout_en` is 1 and `bus_dout` stays stable. During a write acknowledge `bus_dout_en` is 0.
- R10: `msg_all` follows control bit 6 and `split_mode` follows control bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | CH_W+1 | Bus address; top bit selects control byte (0) or memory window (1) |
| bus_din | input | DW | Write data from the master |
| bus_dout | output | DW | Read data to the master |
| bus_dout_en | output | 1 | Drive enable for read data |
| bus_ack_n | output | 1 | Acknowledge, active low |
| slot_i | input | 1 | Processor slot pulse from the serial engine |
| mem_sel | output | 2 | Memory selected for the current access |
| mem_addr | output | STR_W+CH_W | Stream and channel word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid while mem_re is high |
| split_mode | output | 1 | Control bit 7 |
| msg_all | output | 1 | Control bit 6 |

## Verification
The bench builds the block with the default values: a two-stage synchronizer, 32 channels, 8 streams and byte-wide data. It generates the slot pulse every 8 cycles. This puts exact latencies in reach: a fast control write acknowledged in 3 cycles, and a slow access acknowledged in the cycle after a slot. The bench also runs control writes at eight different phases of the slot period. Memory models in the bench cover every selector code, split mode, masking on the high connection memory, and ignored writes.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_DM   = 3'd1,
    TGT_CML  = 3'd2,
    TGT_CMH  = 3'd3,
    TGT_CTRL = 3'd4
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } acc_st_e;

  localparam int CR_SPLIT   = 7;
  localparam int CR_MSGALL  = 6;
  localparam int CR_SPARE   = 5;
  localparam int CR_SEL_LSB = 3;
  localparam int CMH_BITS   = 3;
endpackage

// File: rtl/ppa_sync.sv
module ppa_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ppa_ctrl_reg.sv
module ppa_ctrl_reg import ppa_pkg::*; #(
  parameter int DW    = 8,
  parameter int STR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    value,
  output logic             split,
  output logic             msgall,
  output logic [1:0]       sel,
  output logic [STR_W-1:0] stream
);
  localparam logic [DW-1:0] KEEP_MASK = ~(DW'(1) << CR_SPARE);

  logic [DW-1:0] cr_q, cr_d;

  always_comb begin
    cr_d = cr_q;
    if (we) cr_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_q <= '0;
    else        cr_q <= cr_d;
  end

  assign value  = cr_q;
  assign split  = cr_q[CR_SPLIT];
  assign msgall = cr_q[CR_MSGALL];
  assign sel    = cr_q[CR_SEL_LSB +: 2];
  assign stream = cr_q[STR_W-1:0];

  // R2
  spare_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (value[CR_SPARE] == 1'b0));
endmodule

// File: rtl/ppa_decode.sv
module ppa_decode import ppa_pkg::*; #(
  parameter int CH_W  = 5,
  parameter int STR_W = 3
) (
  input  logic                  rw,
  input  logic [CH_W:0]         addr,
  input  logic                  split,
  input  logic [1:0]            sel,
  input  logic [STR_W-1:0]      stream,
  output tgt_e                  tgt,
  output logic [STR_W+CH_W-1:0] waddr
);
  logic [1:0] eff;

  always_comb begin
    if (split) eff = rw ? 2'b01 : 2'b10;
    else       eff = sel;
    if (!addr[CH_W]) begin
      tgt = TGT_CTRL;
    end else if (!rw && (eff == 2'b01 || eff == 2'b00)) begin
      tgt = TGT_NONE;
    end else begin
      tgt = tgt_e'({1'b0, eff});
    end
  end

  assign waddr = {stream, addr[CH_W-1:0]};
endmodule

// File: rtl/ppa_access_fsm.sv
module ppa_access_fsm import ppa_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          rw,
  input  logic          is_ctrl,
  input  tgt_e          tgt,
  input  logic [DW-1:0] ctrl_val,
  input  logic [DW-1:0] mem_rdata,
  input  logic          slot,
  output logic          ctrl_we,
  output logic          mem_re,
  output logic          mem_we,
  output logic          ack_n,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  localparam logic [DW-1:0] CMH_MASK = DW'((1 << CMH_BITS) - 1);

  acc_st_e       st_q, st_d;
  logic          rd_q, rd_d;
  logic          fast_q, fast_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          tgt_mem;

  assign tgt_mem = (tgt == TGT_DM) || (tgt == TGT_CML) || (tgt == TGT_CMH);

  always_comb begin
    st_d    = st_q;
    rd_d    = rd_q;
    fast_d  = fast_q;
    dout_d  = dout_q;
    ctrl_we = 1'b0;
    mem_re  = 1'b0;
    mem_we  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (active) begin
        rd_d = rw;
        if (is_ctrl && !rw) begin
          ctrl_we = 1'b1;
          fast_d  = 1'b1;
          st_d    = ST_ACK;
        end else begin
          fast_d  = 1'b0;
          st_d    = ST_WAIT;
        end
      end
      ST_WAIT: if (!active) begin
        st_d = ST_IDLE;
      end else if (slot) begin
        st_d = ST_ACK;
        if (rd_q) begin
          mem_re = tgt_mem;
          unique case (tgt)
            TGT_CTRL: dout_d = ctrl_val;
            TGT_CMH:  dout_d = mem_rdata & CMH_MASK;
            TGT_NONE: dout_d = '0;
            default:  dout_d = mem_rdata;
          endcase
        end else begin
          mem_we = (tgt == TGT_CML) || (tgt == TGT_CMH);
        end
      end
      ST_ACK: if (!active) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      fast_q <= 1'b0;
      dout_q <= '0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      fast_q <= fast_d;
      dout_q <= dout_d;
    end
  end

  assign ack_n   = (st_q != ST_ACK);
  assign dout    = dout_q;
  assign dout_en = (st_q == ST_ACK) && rd_q;

  // R4
  slow_ack_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && !fast_q) |-> $past(slot));
  // R9
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && active) |=> !ack_n);
  // R9
  rd_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(!ack_n)) |-> $stable(dout));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

// File: rtl/cpu_bank_port.sv
module cpu_bank_port import ppa_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CH_W        = 5,
  parameter int STR_W       = 3,
  parameter int DW          = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_cs_n,
  input  logic                  bus_ds,
  input  logic                  bus_rw,
  input  logic [CH_W:0]         bus_addr,
  input  logic [DW-1:0]         bus_din,
  output logic [DW-1:0]         bus_dout,
  output logic                  bus_dout_en,
  output logic                  bus_ack_n,
  input  logic                  slot_i,
  output logic [1:0]            mem_sel,
  output logic [STR_W+CH_W-1:0] mem_addr,
  output logic                  mem_re,
  output logic                  mem_we,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  split_mode,
  output logic                  msg_all
);
  localparam logic [DW-1:0] CMH_MASK = DW'((1 << CMH_BITS) - 1);

  logic             rst_s_n;
  logic [1:0]       strb_s;
  logic             active;
  logic             ctrl_we;
  logic [DW-1:0]    ctrl_val;
  logic [1:0]       cr_sel;
  logic [STR_W-1:0] cr_stream;
  tgt_e             tgt;

  ppa_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  ppa_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_bus_sync (
    .clk(clk), .rst_n(rst_s_n), .d({bus_cs_n, bus_ds}), .q(strb_s));

  assign active = !strb_s[1] && strb_s[0];

  ppa_ctrl_reg #(.DW(DW), .STR_W(STR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .we(ctrl_we), .wdata(bus_din),
    .value(ctrl_val), .split(split_mode), .msgall(msg_all),
    .sel(cr_sel), .stream(cr_stream));

  ppa_decode #(.CH_W(CH_W), .STR_W(STR_W)) u_dec (
    .rw(bus_rw), .addr(bus_addr), .split(split_mode), .sel(cr_sel),
    .stream(cr_stream), .tgt(tgt), .waddr(mem_addr));

  ppa_access_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .active(active), .rw(bus_rw),
    .is_ctrl(!bus_addr[CH_W]), .tgt(tgt), .ctrl_val(ctrl_val),
    .mem_rdata(mem_rdata), .slot(slot_i), .ctrl_we(ctrl_we),
    .mem_re(mem_re), .mem_we(mem_we), .ack_n(bus_ack_n),
    .dout(bus_dout), .dout_en(bus_dout_en));

  assign mem_sel   = tgt[1:0];
  assign mem_wdata = (tgt == TGT_CMH) ? (bus_din & CMH_MASK) : bus_din;

  // R6
  split_read_dm_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (split_mode && mem_re) |-> (mem_sel == 2'b01));
  // R6
  split_write_cml_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (split_mode && mem_we) |-> (mem_sel == 2'b10));
  // R8
  no_dm_write_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_we |-> (mem_sel[1] == 1'b1));
  // R4
  strobe_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_re || mem_we) |-> (slot_i && bus_ack_n));
endmodule

// File: tb/tb_cpu_bank_port.sv
module tb_cpu_bank_port;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int SLOT_PER = 8;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, ack_n, slot = 1'b0;
  logic [1:0] mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_re, mem_we, split_mode, msg_all;

  int total = 0, bad = 0;
  int cyc = 0, last_slot = -100;
  int we_cnt = 0, cmh_bad = 0;
  logic [7:0] cml_m [256];
  logic [7:0] cmh_m [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_bank_port dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_ds(ds), .bus_rw(rw),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_dout_en(dout_en),
    .bus_ack_n(ack_n), .slot_i(slot), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .split_mode(split_mode), .msg_all(msg_all));

  function automatic logic [7:0] dm_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    slot = ((cyc % SLOT_PER) == 0);
    if (slot) last_slot = cyc;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        cml_m[i] <= 8'h00;
        cmh_m[i] <= (i == 200) ? 8'hFE : 8'h00;
      end
    end else if (mem_we) begin
      we_cnt = we_cnt + 1;
      if (mem_sel == 2'b11 && mem_wdata[7:3] != 5'd0) cmh_bad = cmh_bad + 1;
      if (mem_sel == 2'b10) cml_m[mem_addr] <= mem_wdata;
      if (mem_sel == 2'b11) cmh_m[mem_addr] <= mem_wdata;
    end
  end

  always_comb begin
    case (mem_sel)
      2'b01:   mem_rdata = dm_val(mem_addr);
      2'b10:   mem_rdata = cml_m[mem_addr];
      2'b11:   mem_rdata = cmh_m[mem_addr];
      default: mem_rdata = 8'hEE;
    endcase
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic [5:0] a, input logic [7:0] wd,
                        input int hold, output logic [7:0] rv, output int lat,
                        output logic den, output logic slot_ok,
                        output logic held_ok, output int rel);
    lat = -1; held_ok = 1'b1; rel = -1; den = 1'b0; rv = '0; slot_ok = 1'b0;
    @(negedge clk); #1;
    rw = r; addr = a; din = wd; cs_n = 1'b0; ds = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk); #1;
      if (!ack_n) begin lat = i; break; end
    end
    slot_ok = (last_slot == cyc - 1);
    rv = dout; den = dout_en;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk); #1;
      if (ack_n || dout != rv || dout_en != den) held_ok = 1'b0;
    end
    ds = 1'b0; cs_n = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk); #1;
      if (ack_n) begin rel = i; break; end
    end
  endtask

  // {rd, addr[5:0], wdata, expected read data, requirement number}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 6'h00, 8'h13, 8'h00, 4'd2},  // R2 sel CML stream 3
    {1'b0, 6'h2A, 8'hC4, 8'h00, 4'd5},  // R5
    {1'b1, 6'h2A, 8'h00, 8'hC4, 4'd5},  // R5
    {1'b0, 6'h1F, 8'h1D, 8'h00, 4'd2},  // R2 low bits ignored; sel CMH stream 5
    {1'b0, 6'h21, 8'hFF, 8'h00, 4'd7},  // R7
    {1'b1, 6'h21, 8'h00, 8'h07, 4'd7},  // R7
    {1'b1, 6'h00, 8'h00, 8'h1D, 4'd2},  // R2
    {1'b0, 6'h00, 8'h0A, 8'h00, 4'd2},  // R2 sel DM stream 2
    {1'b1, 6'h27, 8'h00, 8'h1D, 4'd5},  // R5 dm[71]
    {1'b0, 6'h27, 8'h55, 8'h00, 4'd8},  // R8 ignored
    {1'b1, 6'h27, 8'h00, 8'h1D, 4'd8},  // R8
    {1'b0, 6'h00, 8'hDB, 8'h00, 4'd6},  // R6 split, msg, CMH, stream 3
    {1'b1, 6'h00, 8'h00, 8'hDB, 4'd2},  // R2
    {1'b1, 6'h2A, 8'h00, 8'h30, 4'd6},  // R6 read from DM
    {1'b0, 6'h2A, 8'h77, 8'h00, 4'd6},  // R6 write to CML
    {1'b0, 6'h00, 8'h13, 8'h00, 4'd6},  // R6
    {1'b1, 6'h2A, 8'h00, 8'h77, 4'd6},  // R6
    {1'b0, 6'h00, 8'h2B, 8'h00, 4'd2},  // R2 spare bit written
    {1'b1, 6'h00, 8'h00, 8'h0B, 4'd2},  // R2
    {1'b0, 6'h00, 8'h02, 8'h00, 4'd8},  // R8 sel 00
    {1'b0, 6'h25, 8'h99, 8'h00, 4'd8},  // R8
    {1'b1, 6'h25, 8'h00, 8'h00, 4'd8}   // R8
  };

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int lat, rel, wc;
    logic den, sok, hok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "ack_n", ack_n, 1);
    check("R1", "dout_en", dout_en, 0);
    check("R1", "split", split_mode, 0);
    check("R1", "msg_all", msg_all, 0);
    access(1'b1, 6'h00, 8'h00, 0, rv, lat, den, sok, hok, rel);
    check("R1", "ctrl reset value", rv, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic rd;
      logic [5:0] a;
      logic [7:0] wd, ex;
      string rq;
      {rd, a, wd, ex} = VEC[v][26:4];
      rq = $sformatf("R%0d", VEC[v][3:0]);
      access(rd, a, wd, 0, rv, lat, den, sok, hok, rel);
      if (rd) begin
        check(rq, $sformatf("vec%0d read data", v), rv, ex);
        check("R9", $sformatf("vec%0d dout_en", v), den, 1);
        check("R4", $sformatf("vec%0d ack after slot", v), sok, 1);
      end else begin
        check("R9", $sformatf("vec%0d dout_en on write", v), den, 0);
        if (!a[5]) check("R3", $sformatf("vec%0d fast ack", v), lat, SYNC + 1);
        else       check("R4", $sformatf("vec%0d ack after slot", v), sok, 1);
      end
      check("R9", $sformatf("vec%0d release", v), rel, SYNC + 1);
    end

    // R3: fast control write at every phase of the slot period
    for (int p = 0; p < SLOT_PER; p++) begin
      repeat (p) @(negedge clk);
      access(1'b0, 6'h05, 8'h13, 0, rv, lat, den, sok, hok, rel);
      check("R3", $sformatf("phase%0d fast ack", p), lat, SYNC + 1);
    end

    // R10: mode outputs follow control bits 7 and 6
    access(1'b0, 6'h00, 8'hC0, 0, rv, lat, den, sok, hok, rel);
    check("R10", "split on", split_mode, 1);
    check("R10", "msg_all on", msg_all, 1);
    access(1'b0, 6'h00, 8'h40, 0, rv, lat, den, sok, hok, rel);
    check("R10", "split off", split_mode, 0);
    check("R10", "msg_all held", msg_all, 1);
    access(1'b0, 6'h00, 8'h0A, 0, rv, lat, den, sok, hok, rel);
    check("R10", "msg_all off", msg_all, 0);

    // R8: writes to data memory and to selector 00 raise no memory write
    wc = we_cnt;
    access(1'b0, 6'h31, 8'hAA, 0, rv, lat, den, sok, hok, rel);
    check("R8", "dm write ack", lat > 0, 1);
    access(1'b0, 6'h00, 8'h04, 0, rv, lat, den, sok, hok, rel);
    access(1'b0, 6'h31, 8'hAB, 0, rv, lat, den, sok, hok, rel);
    check("R8", "mem_we count", we_cnt - wc, 0);

    // R7: stored high bits of the high connection memory are masked on read
    access(1'b0, 6'h00, 8'h1E, 0, rv, lat, den, sok, hok, rel);
    access(1'b1, 6'h28, 8'h00, 0, rv, lat, den, sok, hok, rel);
    check("R7", "cmh read mask", rv, 8'h06);
    check("R7", "cmh write data high bits", cmh_bad, 0);

    // R9: acknowledge and data held while the strobe is held
    access(1'b0, 6'h00, 8'h13, 0, rv, lat, den, sok, hok, rel);
    access(1'b1, 6'h2A, 8'h00, 6, rv, lat, den, sok, hok, rel);
    check("R9", "held read data", rv, 8'h77);
    check("R9", "ack and data held", hok, 1);
    check("R9", "release after hold", rel, SYNC + 1);
    // R5: address formed from stream and channel
    access(1'b0, 6'h00, 8'h17, 0, rv, lat, den, sok, hok, rel);
    access(1'b0, 6'h3F, 8'h5C, 0, rv, lat, den, sok, hok, rel);
    check("R5", "cml[255] written", cml_m[255], 8'h5C);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule